// File: doc/BRIEF.md
# Bidirectional Sequential-Stream Prefetcher

This block watches the stream of demand accesses that a cache sees, one line address per cycle, and tries to spot accesses walking through memory one line at a time. Rising walks are tracked in a twelve-entry ascending table and falling walks in a four-entry descending table. When a new access lands on the line directly above an ascending entry, the block asks for the line after it. When a new access lands on the line directly below a descending entry, it asks for the line before it. Either way the matching entry moves forward to the new line, so a single entry follows the whole walk.

An access that matches no entry is written into both tables, because its direction is not yet known. Each table replaces its least-recently-used entry. A request is raised only if the requested line stays in the same 4 KB page as the access that caused it. The output is one registered request slot with a valid/ready handshake. If the consumer stalls, the slot keeps its request until a newer trigger overwrites it.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset `pf_valid` is low and both tables are empty, so the first access after reset never produces a request.
- R2: An access to line L, while a valid ascending entry holds L-1, makes `pf_valid` high with `pf_line` = L+1 on the next clock edge.
- R3: An access to line L, while a valid descending entry holds L+1 and no ascending entry holds L-1, makes `pf_valid` high with `pf_line` = L-1 on the next clock edge.
- R4: On a hit, the matching entry takes the new line L and its valid set does not change. The walk L, L+1, L+2 therefore keeps triggering, and the old address is no longer tracked.
- R5: An access that hits no entry is written into both tables and issues no request. A later access to either neighbouring line triggers in that neighbour's direction.
- R6: Each table replaces its least-recently-used entry, where a hit or a fill counts as a use. The ascending table keeps 12 lines and the descending table keeps 4. After five unrelated misses, the oldest one is gone from the descending table but is still held in the ascending table.
- R7: If an access hits both tables, the ascending table wins. Only the ascending entry is updated, and the request is for L+1.
- R8: No request is raised when the requested line lies in a different page from L, where a page is 2^PAGE_BITS lines (64 lines of 64 B = 4 KB by default). The matching entry is still advanced.
- R9: While `pf_valid` is high and `pf_ready` is low, the request is held unchanged unless a new trigger arrives, in which case the new request replaces it. A cycle with `pf_valid` and `pf_ready` both high and no new trigger clears `pf_valid`.
- R10: Each access produces at most one request, and that request is exactly one line from the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Demand access present this cycle |
| acc_line | input | LINE_W | Line address of the demand access |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_line | output | LINE_W | Line address of the offered request |
| pf_ready | input | 1 | Consumer takes the offered request this cycle |

## Verification
A wrong table entry or a wrong recency order never shows at the ports by itself. It shows only when a later access should hit that entry: the request is then missing, or it appears with the wrong line, one edge after that access. Random walks over a narrow address window, with nearby lines revisited often, force evictions and adjacency hits within a few cycles of each other. The bench model compares every cycle, so a corrupted entry is caught at the first access that depends on it. Directed sequences cover the eviction boundary, the case where both tables hit, page edges, and stalls.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {DIR_ASC = 1'b0, DIR_DESC = 1'b1} sp_dir_e;
endpackage

// File: rtl/sp_lru.sv
module sp_lru #(
  parameter int DEPTH = 12
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   touch_en,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] touch_idx,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] victim_idx
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IW-1:0]    age_q [DEPTH];
  logic [DEPTH-1:0] is_oldest;

  for (genvar g = 0; g < DEPTH; g++) begin : g_old
    assign is_oldest[g] = (age_q[g] == IW'(DEPTH - 1));
  end

  always_comb begin
    victim_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (is_oldest[i]) victim_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IW'(i) == touch_idx)             age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  // R6: the ages always stay a permutation, so exactly one entry is oldest
  assert_single_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_oldest) == 1);
endmodule

// File: rtl/sp_stream_table.sv
module sp_stream_table import sp_pkg::*; #(
  parameter int      DEPTH  = 12,
  parameter int      LINE_W = 20,
  parameter sp_dir_e DIR    = DIR_ASC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe_valid,
  input  logic [LINE_W-1:0] probe_line,
  input  logic              upd_en,
  input  logic              alloc_en,
  output logic              hit
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LINE_W-1:0] addr_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  match;
  logic [IW-1:0]     hit_idx, victim_idx, touch_idx;
  logic              touch_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    if (DIR == DIR_ASC) begin : g_asc
      assign match[g] = vld_q[g] && (LINE_W'(addr_q[g] + 1'b1) == probe_line);
    end else begin : g_desc
      assign match[g] = vld_q[g] && (LINE_W'(probe_line + 1'b1) == addr_q[g]);
    end
  end

  assign hit = probe_valid && (|match);

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (match[i]) hit_idx = IW'(i);
  end

  assign touch_en  = (upd_en && hit) || alloc_en;
  assign touch_idx = alloc_en ? victim_idx : hit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) addr_q[i] <= '0;
    end else if (touch_en) begin
      addr_q[touch_idx] <= probe_line;
      vld_q[touch_idx]  <= 1'b1;
    end
  end

  sp_lru #(.DEPTH(DEPTH)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .victim_idx(victim_idx)
  );

  // R4: advancing a hit entry never changes which entries are valid
  assert_hit_keeps_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && hit && !alloc_en) |=> $stable(vld_q));
  // R5: a fill leaves at least one valid entry behind
  assert_fill_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> (|vld_q));
endmodule

// File: rtl/sp_pf_slot.sv
module sp_pf_slot #(
  parameter int LINE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [LINE_W-1:0] load_line,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [LINE_W-1:0] pf_line
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_line  <= '0;
    end else if (load_en) begin
      pf_valid <= 1'b1;
      pf_line  <= load_line;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
  end

  // R9: a stalled request is held unchanged
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !load_en) |=> (pf_valid && $stable(pf_line)));
  // R9: an accepted request with nothing newer leaves the slot empty
  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready && !load_en) |=> !pf_valid);
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher import sp_pkg::*; #(
  parameter int LINE_W    = 20,
  parameter int ASC_DEPTH = 12,
  parameter int DSC_DEPTH = 4,
  parameter int PAGE_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [LINE_W-1:0] acc_line,
  output logic              pf_valid,
  output logic [LINE_W-1:0] pf_line,
  input  logic              pf_ready
);
  function automatic logic [LINE_W-1:0] step_line(input logic [LINE_W-1:0] l, input sp_dir_e d);
    return (d == DIR_ASC) ? LINE_W'(l + 1'b1) : LINE_W'(l - 1'b1);
  endfunction

  function automatic logic same_page(input logic [LINE_W-1:0] a, input logic [LINE_W-1:0] b);
    return (a >> PAGE_BITS) == (b >> PAGE_BITS);
  endfunction

  logic              asc_hit, dsc_hit, any_hit, miss_fill, issue;
  logic [LINE_W-1:0] cand_line;
  sp_dir_e           hit_dir;

  assign any_hit   = asc_hit || dsc_hit;
  assign miss_fill = acc_valid && !any_hit;
  assign hit_dir   = asc_hit ? DIR_ASC : DIR_DESC;
  assign cand_line = step_line(acc_line, hit_dir);
  assign issue     = any_hit && same_page(cand_line, acc_line);

  sp_stream_table #(.DEPTH(ASC_DEPTH), .LINE_W(LINE_W), .DIR(DIR_ASC)) u_asc (
    .clk        (clk),
    .rst_n      (rst_n),
    .probe_valid(acc_valid),
    .probe_line (acc_line),
    .upd_en     (1'b1),
    .alloc_en   (miss_fill),
    .hit        (asc_hit)
  );

  sp_stream_table #(.DEPTH(DSC_DEPTH), .LINE_W(LINE_W), .DIR(DIR_DESC)) u_dsc (
    .clk        (clk),
    .rst_n      (rst_n),
    .probe_valid(acc_valid),
    .probe_line (acc_line),
    .upd_en     (!asc_hit),
    .alloc_en   (miss_fill),
    .hit        (dsc_hit)
  );

  sp_pf_slot #(.LINE_W(LINE_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (issue),
    .load_line(cand_line),
    .pf_ready (pf_ready),
    .pf_valid (pf_valid),
    .pf_line  (pf_line)
  );

  // R10: an issued request is exactly one line from the triggering access
  assert_one_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (pf_valid && ((pf_line == LINE_W'($past(acc_line) + 1'b1)) ||
                            (pf_line == LINE_W'($past(acc_line) - 1'b1)))));
  // R8: an issued request stays in the page of its trigger
  assert_in_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> ((pf_line >> PAGE_BITS) == ($past(acc_line) >> PAGE_BITS)));
  // R7: a double hit resolves upward
  assert_asc_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (asc_hit && dsc_hit && issue) |=> (pf_line == LINE_W'($past(acc_line) + 1'b1)));
  // R5: a miss never raises a new request
  assert_miss_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_fill && !pf_valid) |=> !pf_valid);
endmodule

// File: tb/stream_prefetcher_test.sv
`timescale 1ns/1ps
module stream_prefetcher_test;
  localparam int LW = 20;
  localparam int PB = 6;
  localparam real HALF = 10.0;

  logic clk = 1'b0, rst_n = 1'b0, acc_valid = 1'b0, pf_ready = 1'b1;
  logic [LW-1:0] acc_line = '0;
  logic pf_valid;
  logic [LW-1:0] pf_line;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(HALF) clk = ~clk;

  stream_prefetcher uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
    .pf_valid(pf_valid), .pf_line(pf_line), .pf_ready(pf_ready)
  );

  // Reference model: table 0 ascending, table 1 descending, recency lists MRU first
  logic [LW-1:0] m_a   [2][12];
  bit            m_v   [2][12];
  int            m_ord [2][12];
  int            m_dep [2] = '{12, 4};
  bit            m_pv;
  logic [LW-1:0] m_pl;

  task automatic m_reset();
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 12; i++) begin
        m_a[t][i] = '0; m_v[t][i] = 1'b0; m_ord[t][i] = i;
      end
    m_pv = 1'b0; m_pl = '0;
  endtask

  function automatic int m_find(int t, logic [LW-1:0] l);
    for (int i = 0; i < m_dep[t]; i++) begin
      if (t == 0 && m_v[t][i] && (m_a[t][i] + 20'd1) == l) return i;
      if (t == 1 && m_v[t][i] && (l + 20'd1) == m_a[t][i]) return i;
    end
    return -1;
  endfunction

  task automatic m_touch(int t, int e);
    int p = 0;
    for (int k = 0; k < m_dep[t]; k++) if (m_ord[t][k] == e) p = k;
    for (int k = p; k > 0; k--) m_ord[t][k] = m_ord[t][k-1];
    m_ord[t][0] = e;
  endtask

  task automatic m_step(bit v, logic [LW-1:0] l, bit rdy);
    int uh = v ? m_find(0, l) : -1;
    int dh = v ? m_find(1, l) : -1;
    bit iss = 1'b0;
    logic [LW-1:0] c = '0;
    if (uh >= 0) begin
      m_a[0][uh] = l; m_touch(0, uh); c = l + 20'd1;
      iss = (c[LW-1:PB] == l[LW-1:PB]);
    end else if (dh >= 0) begin
      m_a[1][dh] = l; m_touch(1, dh); c = l - 20'd1;
      iss = (c[LW-1:PB] == l[LW-1:PB]);
    end else if (v) begin
      for (int t = 0; t < 2; t++) begin
        int e = m_ord[t][m_dep[t]-1];
        m_a[t][e] = l; m_v[t][e] = 1'b1; m_touch(t, e);
      end
    end
    if (iss) begin m_pv = 1'b1; m_pl = c; end
    else if (rdy) m_pv = 1'b0;
  endtask

  task automatic check(string tag);
    checks++;
    if (pf_valid !== m_pv || (m_pv && pf_line !== m_pl)) begin
      fails++;
      $display("FAIL %s: got valid=%0b line=%0d, expected valid=%0b line=%0d",
               tag, pf_valid, pf_line, m_pv, m_pl);
    end
  endtask

  // one cycle: drive at negedge, update model, sample at next negedge
  task automatic step(bit v, int l, bit rdy, string tag);
    acc_valid = v; acc_line = LW'(l); pf_ready = rdy;
    m_step(v, LW'(l), rdy);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; acc_valid = 1'b0; pf_ready = 1'b1;
    m_reset();
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(HALF * 2.0 * 200000.0);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk);
    do_reset();
    // R1, R5: first access is a miss
    step(1, 100, 1, "R1 first access quiet");
    // R2, R4: ascending walk advances
    step(1, 101, 1, "R2 ascending next line");
    step(1, 102, 1, "R4 entry advanced");
    step(1, 101, 1, "R4 old address dropped");
    // R3, R5: descending
    step(1, 300, 1, "R5 miss fill");
    step(1, 299, 1, "R3 descending previous line");
    step(1, 298, 1, "R3 descending continues");
    // R8: page edges
    step(1, 190, 1, "R5 miss near edge");
    step(1, 191, 1, "R8 no cross upward");
    step(1, 192, 1, "R8 entry still advanced");
    step(1, 257, 1, "R5 miss near low edge");
    step(1, 256, 1, "R8 no cross downward");
    // R7: both tables hit
    step(1, 500, 1, "R5 seed low");
    step(1, 502, 1, "R5 seed high");
    step(1, 501, 1, "R7 ascending wins");
    // R9: stall, hold, replace, drain
    step(1, 600, 0, "R9 seed");
    step(1, 601, 0, "R9 request raised");
    step(0, 0,   0, "R9 held while stalled");
    step(1, 602, 0, "R9 replaced by newer");
    step(0, 0,   1, "R9 drained");
    step(0, 0,   1, "R9 stays empty");
    // R6: LRU capacity difference
    do_reset();
    for (int k = 0; k < 5; k++) step(1, 1000 + 10 * k, 1, "R6 fill");
    step(1, 999,  1, "R6 descending oldest evicted");
    step(1, 1011, 1, "R6 ascending still held");
    step(1, 1039, 1, "R6 newest descending kept");
    // random walks, R10 and all others against the model
    do_reset();
    begin
      int cur = 2000;
      for (int n = 0; n < 4000; n++) begin
        int r = int'($urandom_range(0, 9));
        bit v = ($urandom_range(0, 4) != 0);
        bit rdy = ($urandom_range(0, 2) != 0);
        if (r < 4) cur = cur + 1;
        else if (r < 7) cur = cur - 1;
        else cur = 1900 + int'($urandom_range(0, 200));
        step(v, cur, rdy, "R10 random walk");
      end
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule